// File: doc/BRIEF.md
# Audio Receive Bit-Clock Generator

This block drives the serial clocks of an audio receive port that owns its clocking. A master audio clock is divided by a fixed integer to form a bit clock with an even duty cycle. Bit clocks are grouped into frames, and the frame clock marks the two halves of each frame: the first half carries the left word and the second half the right word. A two-bit rate selector fixes the number of bit clocks per frame directly. When the selector is zero, the frame size follows the programmed word length.

For 24-bit words held in 32-bit slots, a gating control can silence the last eight bit-clock periods of each slot. During those periods no edges reach the pins and no sample strobe is issued. Alongside the two clocks the block emits a strobe one master clock wide that tells the deserializer when to take a data bit. The block reads its configuration only at frame boundaries. When master mode is off, the finished frame is followed by disabled, quiet outputs so that external clocks can take over.

Top module: `audio_rx_clkgen`

## Requirements
- R1: With the rate selector at 1, 2 or 3, a frame lasts 32, 64 or 128 bit-clock periods, and the word-length input has no effect.
- R2: With the rate selector at 0, the word-length code sets the frame length: code 0 (16-bit) gives 32 periods, code 1 (24-bit) gives 64, and codes 2 (32-bit) and 3 give 64.
- R3: With the rate selector at 0, word-length code 1 and the gating control at 0, positions 24 to 31 of each 32-period slot carry no bit-clock pulse and no strobe, so a 64-period frame holds 48 pulses.
- R4: With the rate selector at 0, word-length code 1 and the gating control at 1, every one of the 64 periods is clocked and strobed.
- R5: The gating control has no effect while the rate selector is nonzero.
- R6: With master mode at 0, the current frame completes and after it the output enable, the bit clock, the frame clock and the strobe all stay at 0. The same quiet state holds during reset.
- R7: The frame clock is low for the first half of each frame and high for the second. It changes only while the bit clock is low, at the start of a bit period.
- R8: One bit-clock period lasts DIV master clocks (DIV even). The bit clock is low for the first DIV/2 and high for the last DIV/2.
- R9: The strobe is one master clock wide. It is high exactly in the master-clock cycle in which the bit clock rises, and it is absent in gated periods.
- R10: Configuration inputs that change mid-frame take effect only from the next frame boundary, so the frame in progress keeps its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master audio clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_master_i | input | 1 | 1 = drive clocks, 0 = leave them to an external source |
| cfg_rate_i | input | 2 | Frame-rate selector (0 = from word length) |
| cfg_wlen_i | input | 2 | Word length code: 0 = 16, 1 = 24, 2 or 3 = 32 |
| cfg_nogate_i | input | 1 | 1 = keep clocking the 24-bit slot tail |
| bclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Frame clock, low = left half |
| bit_en_o | output | 1 | Sample strobe, one master clock wide |
| clk_oe_o | output | 1 | Output enable for both clocks |

## Verification
Two events can fall in the same master-clock cycle. The frame-boundary wrap of the bit counter can coincide with a configuration change, and the end of the tail gating can coincide with the frame clock's toggle at the slot edge. The first is provoked by changing the rate selector in the middle of a frame. It is judged by measuring that the frame in progress keeps its old length and the next frame takes the new one. The second is covered by sweeping every selector, word-length and gating combination, and for each one counting the master clocks, strobes, frame-clock high cycles and bit-clock high cycles over a whole frame against counts derived arithmetically.

// File: rtl/audio_rx_clkgen_pkg.sv
package audio_rx_clkgen_pkg;

  typedef enum logic [1:0] {
    RATE_FROM_WLEN = 2'b00,
    RATE_32        = 2'b01,
    RATE_64        = 2'b10,
    RATE_128       = 2'b11
  } rate_sel_e;

  typedef enum logic [1:0] {
    WLEN_16  = 2'b00,
    WLEN_24  = 2'b01,
    WLEN_32  = 2'b10,
    WLEN_32X = 2'b11
  } wlen_e;

  typedef struct packed {
    logic      master;
    rate_sel_e rate;
    wlen_e     wlen;
    logic      nogate;
  } rx_clk_cfg_t;

  // largest frame is 2**FRAME_LOG2_MAX bit periods
  localparam int unsigned FRAME_LOG2_MAX = 7;

  function automatic logic [2:0] frame_log2(input rx_clk_cfg_t c);
    logic [2:0] r;
    unique case (c.rate)
      RATE_32:  r = 3'd5;
      RATE_64:  r = 3'd6;
      RATE_128: r = 3'd7;
      default:  r = (c.wlen == WLEN_16) ? 3'd5 : 3'd6;
    endcase
    return r;
  endfunction

  function automatic logic tail_gate_en(input rx_clk_cfg_t c);
    return (c.rate == RATE_FROM_WLEN) && (c.wlen == WLEN_24) && !c.nogate;
  endfunction

endpackage

// File: rtl/rx_rst_sync.sv
module rx_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/rx_cfg_hold.sv
module rx_cfg_hold
  import audio_rx_clkgen_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  rx_clk_cfg_t cfg_i,
  input  logic        frame_end_i,
  output rx_clk_cfg_t cfg_o
);

  rx_clk_cfg_t cfg_q, cfg_d;
  logic        load;

  // idle: follow the inputs freely; running: only at the frame wrap
  assign load = !cfg_q.master || frame_end_i;

  always_comb begin
    cfg_d = cfg_q;
    if (load) cfg_d = cfg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

  AST_CFG_FRAME_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.master && !frame_end_i) |=> $stable(cfg_q)); // R10

endmodule

// File: rtl/rx_bit_divider.sv
module rx_bit_divider #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic bit_last_o,
  output logic phase_hi_o,
  output logic rise_o
);

  localparam int unsigned DW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int unsigned HALF = DIV / 2;
  localparam logic [DW-1:0] LAST_CNT = DW'(DIV - 1);
  localparam logic [DW-1:0] HALF_CNT = DW'(HALF);

  logic [DW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en     = run_i;
  assign bit_last_o = run_i && (cnt_q == LAST_CNT);
  assign phase_hi_o = (cnt_q >= HALF_CNT);
  assign rise_o     = run_i && (cnt_q == HALF_CNT);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)          cnt_d = '0;
    else if (cnt_en)     cnt_d = (cnt_q == LAST_CNT) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

endmodule

// File: rtl/rx_frame_ctr.sv
module rx_frame_ctr
  import audio_rx_clkgen_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       step_i,
  input  logic [2:0] log2_i,
  input  logic       tail_gate_i,
  output logic       frame_end_o,
  output logic       right_half_o,
  output logic       gated_o
);

  localparam int unsigned BW = FRAME_LOG2_MAX;

  logic [BW-1:0] bit_q, bit_d, last_idx;

  always_comb begin
    unique case (log2_i)
      3'd5:    begin last_idx = BW'(31);  right_half_o = bit_q[4]; end
      3'd6:    begin last_idx = BW'(63);  right_half_o = bit_q[5]; end
      default: begin last_idx = BW'(127); right_half_o = bit_q[6]; end
    endcase
  end

  assign frame_end_o = step_i && (bit_q == last_idx);
  // slot position 24..31 when slots are 32 periods wide
  assign gated_o     = tail_gate_i && bit_q[4] && bit_q[3];

  always_comb begin
    bit_d = bit_q;
    if (!run_i)           bit_d = '0;
    else if (frame_end_o) bit_d = '0;
    else if (step_i)      bit_d = bit_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bit_q <= '0;
    else         bit_q <= bit_d;
  end

  AST_BIT_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (bit_q <= last_idx)); // R10

endmodule

// File: rtl/audio_rx_clkgen.sv
module audio_rx_clkgen
  import audio_rx_clkgen_pkg::*;
#(
  parameter int unsigned DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_master_i,
  input  logic [1:0] cfg_rate_i,
  input  logic [1:0] cfg_wlen_i,
  input  logic       cfg_nogate_i,
  output logic       bclk_o,
  output logic       lrck_o,
  output logic       bit_en_o,
  output logic       clk_oe_o
);

  logic        rst_n;
  rx_clk_cfg_t cfg_in, cfg_act;
  logic        run, bit_last, phase_hi, rise;
  logic        frame_end, right_half, gated;
  logic        bclk_d, lrck_d, en_d, oe_d;
  logic        bclk_q, lrck_q, en_q, oe_q;

  always_comb begin
    cfg_in.master = cfg_master_i;
    cfg_in.rate   = rate_sel_e'(cfg_rate_i);
    cfg_in.wlen   = wlen_e'(cfg_wlen_i);
    cfg_in.nogate = cfg_nogate_i;
  end

  rx_rst_sync i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  rx_cfg_hold i_cfg_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .cfg_i       (cfg_in),
    .frame_end_i (frame_end),
    .cfg_o       (cfg_act)
  );

  assign run = cfg_act.master;

  rx_bit_divider #(.DIV(DIV)) i_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .run_i      (run),
    .bit_last_o (bit_last),
    .phase_hi_o (phase_hi),
    .rise_o     (rise)
  );

  rx_frame_ctr i_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .run_i        (run),
    .step_i       (bit_last),
    .log2_i       (frame_log2(cfg_act)),
    .tail_gate_i  (tail_gate_en(cfg_act)),
    .frame_end_o  (frame_end),
    .right_half_o (right_half),
    .gated_o      (gated)
  );

  // registered pin drivers: no combinational glitches on the clocks
  always_comb begin
    oe_d   = run;
    bclk_d = run && phase_hi && !gated;
    lrck_d = run && right_half;
    en_d   = rise && !gated;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      lrck_q <= 1'b0;
      en_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      bclk_q <= bclk_d;
      lrck_q <= lrck_d;
      en_q   <= en_d;
      oe_q   <= oe_d;
    end
  end

  assign bclk_o   = bclk_q;
  assign lrck_o   = lrck_q;
  assign bit_en_o = en_q;
  assign clk_oe_o = oe_q;

  AST_STROBE_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(bclk_o) |-> bit_en_o); // R9

  AST_STROBE_ONE_WIDE: assert property (@(posedge clk_i) disable iff (!rst_n)
    bit_en_o |=> !bit_en_o); // R9

  AST_STROBE_NEEDS_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_n)
    bit_en_o |-> (bclk_o && clk_oe_o)); // R9

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_n)
    !clk_oe_o |-> (!bclk_o && !lrck_o && !bit_en_o)); // R6

  AST_LRCK_AT_BIT_START: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$stable(lrck_o) |-> !bclk_o); // R7

endmodule

// File: tb/test_audio_rx_clkgen.sv
module test_audio_rx_clkgen;

  localparam int DIV = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       master, nogate;
  logic [1:0] rate, wlen;
  logic       bclk, lrck, en, oe;

  int checks = 0;
  int errors = 0;

  logic p_l = 1'b0, c_l = 1'b0, p_b = 1'b0, c_b = 1'b0, c_e = 1'b0, c_o = 1'b0;

  always #5 clk = ~clk;

  audio_rx_clkgen #(.DIV(DIV)) i_audio_rx_clkgen (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cfg_master_i (master),
    .cfg_rate_i   (rate),
    .cfg_wlen_i   (wlen),
    .cfg_nogate_i (nogate),
    .bclk_o       (bclk),
    .lrck_o       (lrck),
    .bit_en_o     (en),
    .clk_oe_o     (oe)
  );

  task automatic sample();
    @(negedge clk);
    p_l = c_l; p_b = c_b;
    c_l = lrck; c_b = bclk; c_e = en; c_o = oe;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // measure one whole frame from a frame-clock fall to the next
  task automatic measure(input int chg_at, input logic [1:0] chg_rate,
                         output int cyc, output int ens, output int lhi,
                         output int bhi, output int badw, output int bade);
    int hirun;
    cyc = 0; ens = 0; lhi = 0; bhi = 0; badw = 0; bade = 0; hirun = 0;
    do sample(); while (!(p_l && !c_l));
    do begin
      cyc++;
      if (c_e) ens++;
      if (c_l) lhi++;
      if (c_b) begin bhi++; hirun++; end
      if (!c_b && p_b && cyc > 1) begin
        if (hirun != DIV/2) badw++;
        hirun = 0;
      end
      if ((c_b && !p_b) != c_e) bade++;
      if (cyc == chg_at) rate = chg_rate;
      sample();
    end while (!(p_l && !c_l));
  endtask

  task automatic run_cfg(input int r, input int wl, input int ng);
    int cyc, ens, lhi, bhi, badw, bade, frame, gat, pulses;
    string rq_len, rq_en;
    rate = 2'(r); wlen = 2'(wl); nogate = ng[0];
    measure(-1, 2'd0, cyc, ens, lhi, bhi, badw, bade);
    measure(-1, 2'd0, cyc, ens, lhi, bhi, badw, bade);
    frame = (r == 1) ? 32 : (r == 2) ? 64 : (r == 3) ? 128 : ((wl == 0) ? 32 : 64);
    gat   = (r == 0 && wl == 1 && ng == 0) ? 16 : 0;
    pulses = frame - gat;
    rq_len = (r != 0) ? "R1" : "R2";
    rq_en  = (r == 0 && wl == 1) ? ((ng == 0) ? "R3" : "R4") : ((r != 0) ? "R5" : "R9");
    check(cyc == frame*DIV, rq_len, "frame master clocks", cyc, frame*DIV);
    check(ens == pulses, rq_en, "strobes per frame", ens, pulses);
    check(lhi == frame*DIV/2, "R7", "frame clock high cycles", lhi, frame*DIV/2);
    check(bhi == pulses*DIV/2, "R8", "bit clock high cycles", bhi, pulses*DIV/2);
    check(badw == 0, "R8", "bit clock high widths off", badw, 0);
    check(bade == 0, "R9", "strobe not at bit clock rise", bade, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog all requirements: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc, ens, lhi, bhi, badw, bade, bad;
    rst_n = 1'b0; master = 1'b1; rate = 2'd0; wlen = 2'd0; nogate = 1'b0;
    repeat (4) sample();
    check(!c_o && !c_b && !c_l && !c_e, "R6", "outputs during reset",
          {c_o, c_b, c_l, c_e}, 0);
    rst_n = 1'b1;

    // full sweep of selector, word length and gating control
    for (int r = 0; r < 4; r++)
      for (int wl = 0; wl < 4; wl++)
        for (int ng = 0; ng < 2; ng++)
          run_cfg(r, wl, ng);

    // R10: change the selector mid-frame
    rate = 2'd1; wlen = 2'd0; nogate = 1'b0;
    measure(-1, 2'd0, cyc, ens, lhi, bhi, badw, bade);
    measure(20, 2'd3, cyc, ens, lhi, bhi, badw, bade);
    check(cyc == 32*DIV, "R10", "frame with mid-frame change", cyc, 32*DIV);
    check(ens == 32, "R10", "strobes in changed frame", ens, 32);
    measure(-1, 2'd0, cyc, ens, lhi, bhi, badw, bade);
    check(cyc == 128*DIV, "R10", "frame after change", cyc, 128*DIV);

    // R6: drop master mode, outputs go quiet after the frame
    master = 1'b0;
    repeat (130*DIV + 10) sample();
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      sample();
      if (c_o || c_b || c_l || c_e) bad++;
    end
    check(bad == 0, "R6", "active outputs while not master", bad, 0);

    // back to master mode
    master = 1'b1;
    run_cfg(2, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule